// File: doc/BRIEF.md
# Debug Mailbox Data Channel

This block is a two-way word mailbox between a running processor core and an external debug host. The core reaches it through a small word-addressed register port. It stores an outgoing word into the transmit register, reads an incoming word from the receive register, and programs a control register. The host reaches it through a simplified scan-style shift port. A capture step loads a selected source into a shift register, a series of shift steps moves bits through it least-significant bit first, and an update step commits the operation.

Each direction has a ready flag. The producer's write raises the flag, and the consumer's read drops it. Writing to a direction whose flag is still raised replaces the stored word and raises a sticky overrun bit. The host can poll the flags through a status capture. It can also rely on an external event pin that follows the transmit flag when enabled. Toward the core, each direction can raise a one-cycle exception request: one when the host has drained the transmit word, and one when a new receive word has landed.

Top module: `dbg_mailbox`

## Requirements
- R1: A core write with `core_addr` = 0 stores `core_wdata` in the transmit register and sets transmit-ready on the next clock edge.
- R2: A host read with `host_sel` = 1 (capture, then 32 shifts, then update) presents the transmit word on `host_tdo` least-significant bit first, starting right after capture. The update edge clears transmit-ready.
- R3: A host write with `host_sel` = 2 shifts `host_tdi` in least-significant bit first. The receive register and receive-ready change only at the update edge, never during the shifts.
- R4: A core read with `core_addr` = 1 returns the receive word combinationally and clears receive-ready at that clock edge.
- R5: A write to a direction whose ready flag is still set replaces the stored word and sets that direction's sticky overrun bit. This is status bit 2 for transmit and bit 3 for receive. A core write to address 3 with a 1 in an overrun bit position clears that bit.
- R6: The control register at address 2 is core writable and readable. Bit 0 is the event-pin enable, bit 1 the transmit exception enable and bit 2 the receive exception enable.
- R7: `event_pin` is high exactly when the pin enable is set and transmit-ready is set.
- R8: `tx_exc_req` pulses high for the one cycle after a host read update, and only when the transmit exception enable is set.
- R9: `rx_exc_req` pulses high for the one cycle after a host write update, and only when the receive exception enable is set.
- R10: The status word reads the same from core address 3 and from a host capture with `host_sel` = 0. Bit 0 is transmit-ready, bit 1 receive-ready, bit 2 transmit overrun and bit 3 receive overrun. A host status read changes no flag.
- R11: After reset, all flags, data, control bits and the outputs `event_pin`, `tx_exc_req` and `rx_exc_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_wr | input | 1 | Core register write strobe |
| core_rd | input | 1 | Core register read strobe |
| core_addr | input | AW | Core word address: 0 transmit, 1 receive, 2 control, 3 status |
| core_wdata | input | DW | Core write data |
| core_rdata | output | DW | Core read data (combinational; the transmit address reads zero) |
| host_sel | input | 2 | Host register select: 0 status, 1 transmit read, 2 receive write |
| host_capture | input | 1 | Load the selected source into the shift register |
| host_shift | input | 1 | Shift one bit, `host_tdi` in at the top |
| host_update | input | 1 | Commit the selected host operation |
| host_tdi | input | 1 | Host serial data in |
| host_tdo | output | 1 | Host serial data out (bit 0 of the shift register) |
| event_pin | output | 1 | External transmit-available indication |
| tx_exc_req | output | 1 | Core exception request: transmit register drained |
| rx_exc_req | output | 1 | Core exception request: receive word arrived |

## Verification
The assertions assume the host raises at most one of capture, shift and update in a cycle. They also assume `host_sel` holds steady across a whole capture-shift-update sequence. The stimulus meets both by having host tasks drive a single strobe per cycle and set the select before the sequence begins. Core accesses and host accesses are also kept to separate cycles. The same-cycle collisions, where the write wins, are therefore covered by the RTL rules rather than by stimulus.

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_wr,
  input  logic          core_rd,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata,
  input  logic [1:0]    host_sel,
  input  logic          host_capture,
  input  logic          host_shift,
  input  logic          host_update,
  input  logic          host_tdi,
  output logic          host_tdo,
  output logic          event_pin,
  output logic          tx_exc_req,
  output logic          rx_exc_req
);
  localparam logic [AW-1:0] A_TX = AW'(0);
  localparam logic [AW-1:0] A_RX = AW'(1);
  localparam logic [AW-1:0] A_CTRL = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_TX = 2'd1;
  localparam logic [1:0] SEL_RX = 2'd2;

  logic [DW-1:0] tx_data, rx_data, sr, cap_val;
  logic [2:0]    ctrl;
  logic          tx_ready, rx_ready, tx_ovr, rx_ovr;
  logic [3:0]    stat;

  wire tx_wr   = core_wr && core_addr == A_TX;
  wire ctrl_wr = core_wr && core_addr == A_CTRL;
  wire stat_wr = core_wr && core_addr == A_STAT;
  wire rx_rd   = core_rd && core_addr == A_RX;
  wire tx_done = host_update && host_sel == SEL_TX;
  wire rx_wr   = host_update && host_sel == SEL_RX;

  assign stat      = {rx_ovr, tx_ovr, rx_ready, tx_ready};
  assign host_tdo  = sr[0];
  assign event_pin = ctrl[0] & tx_ready;

  always_comb begin
    case (host_sel)
      SEL_STAT: cap_val = DW'(stat);
      SEL_TX:   cap_val = tx_data;
      default:  cap_val = '0;
    endcase
  end

  always_comb begin
    case (core_addr)
      A_RX:    core_rdata = rx_data;
      A_CTRL:  core_rdata = DW'(ctrl);
      A_STAT:  core_rdata = DW'(stat);
      default: core_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data    <= '0;
      rx_data    <= '0;
      sr         <= '0;
      ctrl       <= '0;
      tx_ready   <= 1'b0;
      rx_ready   <= 1'b0;
      tx_ovr     <= 1'b0;
      rx_ovr     <= 1'b0;
      tx_exc_req <= 1'b0;
      rx_exc_req <= 1'b0;
    end else begin
      if (host_capture)    sr <= cap_val;
      else if (host_shift) sr <= {host_tdi, sr[DW-1:1]};
      if (tx_wr)   tx_data <= core_wdata;
      if (rx_wr)   rx_data <= sr;
      if (ctrl_wr) ctrl    <= core_wdata[2:0];
      tx_ready   <= tx_wr | (tx_ready & ~tx_done);
      rx_ready   <= rx_wr | (rx_ready & ~rx_rd);
      tx_ovr     <= (tx_ovr & ~(stat_wr & core_wdata[2])) | (tx_wr & tx_ready & ~tx_done);
      rx_ovr     <= (rx_ovr & ~(stat_wr & core_wdata[3])) | (rx_wr & rx_ready & ~rx_rd);
      tx_exc_req <= tx_done & ctrl[1];
      rx_exc_req <= rx_wr & ctrl[2];
    end
  end

  // R1
  tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> tx_ready && tx_data == $past(core_wdata));
  // R2
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_wr) |=> !tx_ready);
  // R3
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_wr |=> $stable(rx_data));
  // R4
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_wr) |=> !rx_ready);
  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovr && !stat_wr) |=> tx_ovr);
  // R8
  tx_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_exc_req |-> $past(tx_done));
  // R9
  rx_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_exc_req) |-> rx_ready);
endmodule

// File: tb/dbg_mailbox_test.sv
module dbg_mailbox_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic core_wr = 0, core_rd = 0;
  logic [1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0, core_rdata;
  logic [1:0] host_sel = '0;
  logic host_capture = 0, host_shift = 0, host_update = 0, host_tdi = 0;
  logic host_tdo, event_pin, tx_exc_req, rx_exc_req;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_mailbox #(.DW(DW), .AW(2)) uut (
    .clk(clk), .rst_n(rst_n), .core_wr(core_wr), .core_rd(core_rd),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .host_sel(host_sel), .host_capture(host_capture), .host_shift(host_shift),
    .host_update(host_update), .host_tdi(host_tdi), .host_tdo(host_tdo),
    .event_pin(event_pin), .tx_exc_req(tx_exc_req), .rx_exc_req(rx_exc_req));

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic core_write(input logic [1:0] a, input logic [DW-1:0] d);
    core_wr = 1; core_addr = a; core_wdata = d; tick; core_wr = 0;
  endtask

  task automatic core_read(input logic [1:0] a, output logic [DW-1:0] d);
    core_rd = 1; core_addr = a; #1 d = core_rdata; tick; core_rd = 0;
  endtask

  task automatic host_read(input logic [1:0] s, output logic [DW-1:0] w);
    host_sel = s; host_capture = 1; tick; host_capture = 0;
    for (int i = 0; i < DW; i++) begin
      w[i] = host_tdo; host_shift = 1; tick; host_shift = 0;
    end
    host_update = 1; tick; host_update = 0;
  endtask

  task automatic host_shift_in(input logic [DW-1:0] w);
    host_sel = 2'd2;
    for (int i = 0; i < DW; i++) begin
      host_tdi = w[i]; host_shift = 1; tick; host_shift = 0;
    end
    host_tdi = 0;
  endtask

  task automatic host_commit;
    host_update = 1; tick; host_update = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] r, w, prev_rx;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    check("R11 event_pin", DW'(event_pin), 0);
    check("R11 tx_exc", DW'(tx_exc_req), 0);
    check("R11 rx_exc", DW'(rx_exc_req), 0);
    core_read(2'd3, r); check("R11 status", r, 0);
    core_read(2'd2, r); check("R11 ctrl", r, 0);
    core_read(2'd1, r); check("R11 rx data", r, 0);
    prev_rx = '0;

    for (int c = 0; c < 8; c++) begin
      w = (32'h9E3779B9 * (c + 1)) ^ (32'h1 << (c * 3));
      core_write(2'd2, DW'(c));
      core_read(2'd2, r); check("R6 ctrl readback", r, DW'(c));
      check("R7 pin idle", DW'(event_pin), 0);
      core_write(2'd0, w);
      core_read(2'd3, r); check("R1 tx ready", r, 1);
      check("R7 pin follows", DW'(event_pin), DW'(c & 1));
      host_read(2'd1, r);
      check("R2 tx word", r, w);
      check("R8 tx exc pulse", DW'(tx_exc_req), DW'((c >> 1) & 1));
      tick;
      check("R8 tx exc one cycle", DW'(tx_exc_req), 0);
      check("R7 pin cleared", DW'(event_pin), 0);
      core_read(2'd3, r); check("R2 tx ready cleared", r, 0);
      host_shift_in(~w);
      core_read(2'd3, r); check("R3 no ready before update", r, 0);
      core_read(2'd1, r); check("R3 rx held before update", r, prev_rx);
      host_commit;
      check("R9 rx exc pulse", DW'(rx_exc_req), DW'((c >> 2) & 1));
      core_read(2'd3, r); check("R3 rx ready", r, 2);
      check("R9 rx exc one cycle", DW'(rx_exc_req), 0);
      core_read(2'd1, r); check("R4 rx word", r, ~w);
      core_read(2'd3, r); check("R4 rx ready cleared", r, 0);
      prev_rx = ~w;
    end
    core_write(2'd2, 0);

    // R5 transmit overrun
    core_write(2'd0, 32'h11111111);
    core_write(2'd0, 32'h22222222);
    core_read(2'd3, r); check("R5 tx overrun set", r, 5);
    host_read(2'd1, r); check("R5 tx overwritten", r, 32'h22222222);
    core_read(2'd3, r); check("R5 tx overrun sticky", r, 4);
    core_write(2'd3, 32'h4);
    core_read(2'd3, r); check("R5 tx overrun cleared", r, 0);
    // R5 receive overrun
    host_shift_in(32'hAAAA0001); host_commit;
    host_shift_in(32'h5555FFFE); host_commit;
    core_read(2'd3, r); check("R5 rx overrun set", r, 32'hA);
    core_read(2'd1, r); check("R5 rx overwritten", r, 32'h5555FFFE);
    core_read(2'd3, r); check("R5 rx overrun sticky", r, 8);
    core_write(2'd3, 32'h8);
    core_read(2'd3, r); check("R5 rx overrun cleared", r, 0);

    // R10 host status capture
    core_write(2'd0, 32'hCAFE0000);
    host_shift_in(32'h0BADF00D); host_commit;
    host_read(2'd0, r); check("R10 host status", r, 3);
    core_read(2'd3, r); check("R10 status unchanged", r, 3);
    host_read(2'd1, r); check("R2 tx word", r, 32'hCAFE0000);
    core_read(2'd1, r); check("R4 rx word", r, 32'h0BADF00D);

    // R2/R3 walking-one sweep over every bit position
    for (int k = 0; k < DW; k++) begin
      w = 32'h1 << k;
      core_write(2'd0, w);
      host_read(2'd1, r); check("R2 walking tx", r, w);
      host_shift_in(w); host_commit;
      core_read(2'd1, r); check("R3 walking rx", r, w);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule